// File: doc/BRIEF.md
# Display plane scanout address generator

This block turns a timing generator's position strobes into a stream of framebuffer byte addresses for one display pipe. Software programs a surface origin, a linear offset, a scanline pitch, a visible-size word and a packed control word through a one-cycle register write port. The timing generator marks the start of each frame and each line and offers active pixels on a valid/ready handshake. For every pixel inside the visible window of an enabled plane the block issues one address and a tag that names the pixel format. A downstream fetch unit consumes these.

Settings are double-buffered. Writes land in pending registers and are copied into the working set on the frame-start strobe, so a frame is never scanned with mixed settings. Disabling the plane is the one exception: it acts at once. Pixel multiply repeats each source pixel horizontally. A tiling flag switches from a plain row-major layout to a tiled layout made of fixed byte-wide, row-tall tiles.

The pixel input stalls when the output cannot move. The pixel input is not ready while the output holds an unaccepted address. It is also not ready in any cycle that carries a frame-start or line-start strobe. A held output keeps its address and tag unchanged until it is taken. An address appears on the output one cycle after its pixel handshake.

Top module: `disp_plane_scanout`

## Requirements
- R1: After reset, out_valid, plane_on and fmt_err are 0 and pix_ready is 1.
- R2: Register selects are 0 control, 1 surface origin, 2 linear offset, 3 pitch, 4 visible size and 5 error clear. Writes to selects 0 to 4 stay pending and take effect only on the next frame_start, with the single exception of disabling in R6. A frame already running keeps its old addresses.
- R3: With control bits 29:26 = 6, the format is 32 bits per pixel in B,G,R,X byte order (4 bytes per pixel) and out_tag = 2. On a linear surface the address is origin + offset + line × pitch + pixel × 4.
- R4: Format code 2 is 1 byte per pixel with out_tag = 0. Format code 5 is 2 bytes per pixel with out_tag = 1. These use the same address formula as R3 with their own byte size.
- R5: A control write with bit 31 set and any other format code leaves the plane off and sets fmt_err. fmt_err then stays set, even across later good writes, until any write to select 5.
- R6: A control write with bit 31 = 0 turns plane_on off in the next cycle, and no address is issued for pixels accepted after it. A write with bit 31 = 1 and a supported format turns the plane on only at the next frame_start.
- R7: The visible-size word holds (width − 1) in bits 31:16 and (height − 1) in bits 15:0. Only a pixel whose column is at most width − 1 and whose line is at most height − 1 yields an address. With multiply 0 and tiling 0, each such pixel yields exactly one address.
- R8: Control bits 21:20 hold the multiply code m. The source column used in the address is the pixel column shifted right by m, and m = 0 means no repetition.
- R9: Control bit 10 = 1 selects tiling, and 0 selects linear. A tile is TILE_W_BYTES wide and TILE_H rows tall, and tiles of one row-group are contiguous. For x = column × bytes per pixel, the address is origin + offset + (line / TILE_H) × pitch × TILE_H + (x / TILE_W_BYTES) × TILE_W_BYTES × TILE_H + (line mod TILE_H) × TILE_W_BYTES + (x mod TILE_W_BYTES).
- R10: pix_ready = (out_valid is 0 or out_ready is 1) and no sync strobe is present in that cycle. An accepted pixel's address appears on the next cycle. While out_valid is 1 and out_ready is 0, the address and tag stay unchanged, and an offered pixel is not counted.
- R11: frame_start sets the line and the column to 0. line_start advances the line by one and returns the column to 0. Each accepted pixel advances the column by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame start strobe; loads pending settings |
| line_start | input | 1 | Next line strobe |
| pix_valid | input | 1 | Active pixel offered |
| pix_ready | output | 1 | Pixel accepted this cycle when high with pix_valid |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Downstream takes the address |
| out_addr | output | ADDR_W | Framebuffer byte address |
| out_tag | output | 2 | Format tag (0 8-bit, 1 16-bit, 2 32-bit BGRX) |
| plane_on | output | 1 | Plane currently generating |
| fmt_err | output | 1 | Sticky unsupported-format flag |

## Verification
The bench builds the block with ADDR_W = 32, TILING_EN = 1, and tiles reduced to TILE_W_BYTES = 64 and TILE_H = 4. With 32-bit pixels, a tile-column boundary is then crossed at column 16, and the row-group base steps after four lines. Both tiled terms can therefore be reached within a few lines and a few dozen pixels. The reduced tile sizes also keep the expected addresses small enough to work out by hand.

// File: rtl/disp_plane_pkg.sv
package disp_plane_pkg;

  localparam int POS_W = 16;

  localparam int CTL_EN_BIT   = 31;
  localparam int CTL_FMT_HI   = 29;
  localparam int CTL_FMT_LO   = 26;
  localparam int CTL_MUL_HI   = 21;
  localparam int CTL_MUL_LO   = 20;
  localparam int CTL_TILE_BIT = 10;

  typedef enum logic [1:0] {
    TAG_IDX8   = 2'd0,
    TAG_RGB16  = 2'd1,
    TAG_BGRX32 = 2'd2,
    TAG_NONE   = 2'd3
  } pix_tag_e;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_ORIGIN = 3'd1,
    SEL_LINOFF = 3'd2,
    SEL_PITCH  = 3'd3,
    SEL_SIZE   = 3'd4,
    SEL_ERRCLR = 3'd5
  } cfg_sel_e;

  typedef struct packed {
    logic     ok;
    pix_tag_e tag;
    logic [1:0] bpp_shift;
  } fmt_info_t;

  typedef struct packed {
    logic       tiled;
    logic [1:0] mult;
    pix_tag_e   tag;
    logic [1:0] bpp_shift;
  } plane_mode_t;

  function automatic fmt_info_t decode_fmt(input logic [3:0] code);
    fmt_info_t f;
    case (code)
      4'd2:    f = '{ok: 1'b1, tag: TAG_IDX8,   bpp_shift: 2'd0};
      4'd5:    f = '{ok: 1'b1, tag: TAG_RGB16,  bpp_shift: 2'd1};
      4'd6:    f = '{ok: 1'b1, tag: TAG_BGRX32, bpp_shift: 2'd2};
      default: f = '{ok: 1'b0, tag: TAG_NONE,   bpp_shift: 2'd0};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/plane_cfg_regs.sv
module plane_cfg_regs
  import disp_plane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              frame_start,
  output logic              act_en,
  output logic [ADDR_W-1:0] act_origin,
  output logic [ADDR_W-1:0] act_pitch,
  output logic [POS_W-1:0]  act_wlast,
  output logic [POS_W-1:0]  act_hlast,
  output plane_mode_t       act_mode,
  output logic              fmt_err
);

  logic [ADDR_W-1:0] pend_origin, pend_off, pend_pitch;
  logic [POS_W-1:0]  pend_wlast, pend_hlast;
  plane_mode_t       pend_mode;
  logic              pend_en;

  fmt_info_t wr_fmt;
  logic      wr_ctrl, wr_go, wr_bad, wr_clr;

  assign wr_fmt  = decode_fmt(cfg_wdata[CTL_FMT_HI:CTL_FMT_LO]);
  assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
  assign wr_go   = cfg_wdata[CTL_EN_BIT] && wr_fmt.ok;
  assign wr_bad  = wr_ctrl && cfg_wdata[CTL_EN_BIT] && !wr_fmt.ok;
  assign wr_clr  = cfg_we && (cfg_sel == SEL_ERRCLR);

  // Pending set: written by software, never seen by the scan path directly
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_origin <= '0;
      pend_off    <= '0;
      pend_pitch  <= '0;
      pend_wlast  <= '0;
      pend_hlast  <= '0;
      pend_mode   <= '{tiled: 1'b0, mult: 2'd0, tag: TAG_NONE, bpp_shift: 2'd0};
      pend_en     <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_ORIGIN: pend_origin <= cfg_wdata[ADDR_W-1:0];
        SEL_LINOFF: pend_off    <= cfg_wdata[ADDR_W-1:0];
        SEL_PITCH:  pend_pitch  <= cfg_wdata[ADDR_W-1:0];
        SEL_SIZE: begin
          pend_wlast <= cfg_wdata[31:16];
          pend_hlast <= cfg_wdata[15:0];
        end
        SEL_CTRL: begin
          pend_en   <= wr_go;
          pend_mode <= '{tiled:     cfg_wdata[CTL_TILE_BIT],
                         mult:      cfg_wdata[CTL_MUL_HI:CTL_MUL_LO],
                         tag:       wr_fmt.tag,
                         bpp_shift: wr_fmt.bpp_shift};
        end
        default: ;
      endcase
    end
  end

  // Working set: copied at frame start; disable acts at once
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_en     <= 1'b0;
      act_origin <= '0;
      act_pitch  <= '0;
      act_wlast  <= '0;
      act_hlast  <= '0;
      act_mode   <= '{tiled: 1'b0, mult: 2'd0, tag: TAG_NONE, bpp_shift: 2'd0};
    end else begin
      if (frame_start) begin
        act_en     <= pend_en;
        act_origin <= pend_origin + pend_off;
        act_pitch  <= pend_pitch;
        act_wlast  <= pend_wlast;
        act_hlast  <= pend_hlast;
        act_mode   <= pend_mode;
      end
      if (wr_ctrl && !wr_go) act_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      fmt_err <= 1'b0;
    else if (wr_bad) fmt_err <= 1'b1;
    else if (wr_clr) fmt_err <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_err && !wr_clr) |=> fmt_err); // R5
  AST_BADFMT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> (!act_en && fmt_err)); // R5
  AST_DISABLE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !cfg_wdata[CTL_EN_BIT]) |=> !act_en); // R6
  AST_ON_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_en && !frame_start) |=> !act_en); // R6
  AST_SET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_origin) && $stable(act_pitch)
                      && $stable(act_wlast) && $stable(act_hlast))); // R2

endmodule

// File: rtl/plane_pos_track.sv
module plane_pos_track
  import disp_plane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TILE_H = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              pix_take,
  input  logic [ADDR_W-1:0] act_pitch,
  output logic [POS_W-1:0]  pix_x,
  output logic [POS_W-1:0]  line_y,
  output logic [ADDR_W-1:0] lin_base,
  output logic [ADDR_W-1:0] tile_base
);

  localparam int TH_LOG2 = $clog2(TILE_H);
  localparam logic [POS_W-1:0] TH_MASK = POS_W'(TILE_H - 1);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic group_end;
  assign group_end = ((line_y & TH_MASK) == TH_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_x     <= '0;
      line_y    <= '0;
      lin_base  <= '0;
      tile_base <= '0;
    end else if (frame_start) begin
      pix_x     <= '0;
      line_y    <= '0;
      lin_base  <= '0;
      tile_base <= '0;
    end else if (line_start) begin
      pix_x <= '0;
      if (line_y != POS_MAX) begin
        line_y   <= line_y + 1'b1;
        lin_base <= lin_base + act_pitch;
        if (group_end) tile_base <= tile_base + (act_pitch << TH_LOG2);
      end
    end else if (pix_take && (pix_x != POS_MAX)) begin
      pix_x <= pix_x + 1'b1;
    end
  end

  AST_FRAME_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pix_x == '0 && line_y == '0)); // R11
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && line_y != POS_MAX)
      |=> (line_y == $past(line_y) + 1'b1 && pix_x == '0)); // R11
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_take && !frame_start && !line_start && pix_x != POS_MAX)
      |=> (pix_x == $past(pix_x) + 1'b1)); // R11

endmodule

// File: rtl/plane_addr_calc.sv
module plane_addr_calc
  import disp_plane_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int TILE_W_BYTES = 512,
  parameter int TILE_H       = 8,
  parameter bit TILING_EN    = 1'b1
) (
  input  plane_mode_t             mode,
  input  logic [POS_W-1:0]        pix_x,
  input  logic [$clog2(TILE_H)-1:0] row_in_tile,
  input  logic [ADDR_W-1:0]       origin,
  input  logic [ADDR_W-1:0]       lin_base,
  input  logic [ADDR_W-1:0]       tile_base,
  output logic [ADDR_W-1:0]       addr
);

  localparam int TW_LOG2 = $clog2(TILE_W_BYTES);
  localparam int TH_LOG2 = $clog2(TILE_H);
  localparam logic [ADDR_W-1:0] TW_MASK = ADDR_W'(TILE_W_BYTES - 1);

  logic [POS_W-1:0]  src_x;
  logic [ADDR_W-1:0] x_bytes, lin_addr;

  assign src_x    = pix_x >> mode.mult;
  assign x_bytes  = ADDR_W'(src_x) << mode.bpp_shift;
  assign lin_addr = origin + lin_base + x_bytes;

  generate
    if (TILING_EN) begin : g_tiled
      logic [ADDR_W-1:0] col_off, row_off, in_off, tile_addr;
      assign col_off   = (x_bytes >> TW_LOG2) << (TW_LOG2 + TH_LOG2);
      assign row_off   = ADDR_W'(row_in_tile) << TW_LOG2;
      assign in_off    = x_bytes & TW_MASK;
      assign tile_addr = origin + tile_base + col_off + row_off + in_off;
      assign addr      = mode.tiled ? tile_addr : lin_addr;
    end else begin : g_linear
      logic lin_unused;
      assign lin_unused = ^{row_in_tile, tile_base, mode.tiled};
      assign addr       = lin_addr;
    end
  endgenerate

endmodule

// File: rtl/disp_plane_scanout.sv
module disp_plane_scanout
  import disp_plane_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int TILE_W_BYTES = 512,
  parameter int TILE_H       = 8,
  parameter bit TILING_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              pix_valid,
  output logic              pix_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_tag,
  output logic              plane_on,
  output logic              fmt_err
);

  localparam int TH_LOG2 = $clog2(TILE_H);

  logic              act_en;
  logic [ADDR_W-1:0] act_origin, act_pitch, lin_base, tile_base, calc_addr;
  logic [POS_W-1:0]  act_wlast, act_hlast, pix_x, line_y;
  plane_mode_t       act_mode;
  logic              pix_take, in_view;

  plane_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .frame_start(frame_start),
    .act_en     (act_en),
    .act_origin (act_origin),
    .act_pitch  (act_pitch),
    .act_wlast  (act_wlast),
    .act_hlast  (act_hlast),
    .act_mode   (act_mode),
    .fmt_err    (fmt_err)
  );

  plane_pos_track #(.ADDR_W(ADDR_W), .TILE_H(TILE_H)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .line_start (line_start),
    .pix_take   (pix_take),
    .act_pitch  (act_pitch),
    .pix_x      (pix_x),
    .line_y     (line_y),
    .lin_base   (lin_base),
    .tile_base  (tile_base)
  );

  plane_addr_calc #(
    .ADDR_W(ADDR_W), .TILE_W_BYTES(TILE_W_BYTES),
    .TILE_H(TILE_H), .TILING_EN(TILING_EN)
  ) u_calc (
    .mode       (act_mode),
    .pix_x      (pix_x),
    .row_in_tile(line_y[TH_LOG2-1:0]),
    .origin     (act_origin),
    .lin_base   (lin_base),
    .tile_base  (tile_base),
    .addr       (calc_addr)
  );

  assign pix_ready = (!out_valid || out_ready) && !frame_start && !line_start;
  assign pix_take  = pix_valid && pix_ready;
  assign in_view   = act_en && (pix_x <= act_wlast) && (line_y <= act_hlast);
  assign plane_on  = act_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_tag   <= TAG_NONE;
    end else if (pix_take) begin
      out_valid <= in_view;
      if (in_view) begin
        out_addr <= calc_addr;
        out_tag  <= act_mode.tag;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_tag))); // R10
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_en && (!out_valid || out_ready)) |=> !out_valid); // R6
  AST_TAG_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tag != TAG_NONE)); // R4

endmodule

// File: tb/disp_plane_scanout_tb_top.sv
module disp_plane_scanout_tb_top;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] origin;
    logic [31:0] off;
    logic [31:0] pitch;
    logic [31:0] size;
    logic [15:0] line;
    logic [15:0] x;
    logic        ev;
    logic [31:0] ea;
    logic [1:0]  et;
    logic [3:0]  req;
  } vec_t;

  // ctrl: bit31 enable, 29:26 format, 21:20 multiply, 10 tiling
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h9800_0000, 32'h1000,  32'h20, 32'h2000, 32'h0063_0031, 16'd3, 16'd5,  1'b1, 32'h7034,  2'd2, 4'd3}, // R3
    '{32'h8800_0000, 32'h4000,  32'h0,  32'h100,  32'h0063_0031, 16'd2, 16'd7,  1'b1, 32'h4207,  2'd0, 4'd4}, // R4
    '{32'h9400_0000, 32'h0,     32'h10, 32'h80,   32'h0063_0031, 16'd1, 16'd9,  1'b1, 32'hA2,    2'd1, 4'd4}, // R4
    '{32'h9800_0000, 32'h100,   32'h0,  32'h40,   32'h0003_0031, 16'd0, 16'd3,  1'b1, 32'h10C,   2'd2, 4'd7}, // R7
    '{32'h9800_0000, 32'h100,   32'h0,  32'h40,   32'h0003_0031, 16'd0, 16'd4,  1'b0, 32'h0,     2'd2, 4'd7}, // R7
    '{32'h9800_0000, 32'h100,   32'h0,  32'h40,   32'h0063_0001, 16'd2, 16'd0,  1'b0, 32'h0,     2'd2, 4'd7}, // R7
    '{32'h9810_0000, 32'h0,     32'h0,  32'h400,  32'h0063_0031, 16'd0, 16'd5,  1'b1, 32'h8,     2'd2, 4'd8}, // R8
    '{32'h9820_0000, 32'h0,     32'h0,  32'h400,  32'h0063_0031, 16'd1, 16'd7,  1'b1, 32'h404,   2'd2, 4'd8}, // R8
    '{32'h9800_0400, 32'h10000, 32'h0,  32'h200,  32'h0063_0031, 16'd5, 16'd17, 1'b1, 32'h10944, 2'd2, 4'd9}, // R9
    '{32'h9800_0400, 32'h10000, 32'h0,  32'h200,  32'h0063_0031, 16'd0, 16'd3,  1'b1, 32'h1000C, 2'd2, 4'd9}  // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        frame_start = 1'b0, line_start = 1'b0, pix_valid = 1'b0;
  logic        out_ready = 1'b1;
  logic        pix_ready, out_valid, plane_on, fmt_err;
  logic [31:0] out_addr;
  logic [1:0]  out_tag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  disp_plane_scanout #(.ADDR_W(32), .TILE_W_BYTES(64), .TILE_H(4), .TILING_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .line_start(line_start), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_tag(out_tag), .plane_on(plane_on), .fmt_err(fmt_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pulse_line();
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
  endtask

  task automatic send_pix(output logic v, output logic [31:0] a, output logic [1:0] t);
    @(negedge clk); pix_valid = 1'b1;
    @(negedge clk); pix_valid = 1'b0;
    v = out_valid; a = out_addr; t = out_tag;
  endtask

  task automatic setup(input logic [31:0] c, o, f, p, s);
    wr(3'd0, c); wr(3'd1, o); wr(3'd2, f); wr(3'd3, p); wr(3'd4, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic v;
    logic [31:0] a;
    logic [1:0] t;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 plane_on",  {31'd0, plane_on},  32'd0);
    chk("R1 fmt_err",   {31'd0, fmt_err},   32'd0);
    chk("R1 pix_ready", {31'd0, pix_ready}, 32'd1);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].ctrl, VECS[i].origin, VECS[i].off, VECS[i].pitch, VECS[i].size);
      pulse_frame();
      for (int l = 0; l < int'(VECS[i].line); l++) pulse_line();
      for (int p = 0; p <= int'(VECS[i].x); p++) send_pix(v, a, t);
      chk($sformatf("R%0d vec%0d valid", VECS[i].req, i), {31'd0, v}, {31'd0, VECS[i].ev});
      if (VECS[i].ev) begin
        chk($sformatf("R%0d vec%0d addr", VECS[i].req, i), a, VECS[i].ea);
        chk($sformatf("R%0d vec%0d tag", VECS[i].req, i), {30'd0, t}, {30'd0, VECS[i].et});
      end
    end

    // R2: mid-frame origin write deferred to next frame
    setup(32'h9800_0000, 32'h1000, 32'h0, 32'h100, 32'h0063_0031);
    pulse_frame();
    wr(3'd1, 32'h8000);
    send_pix(v, a, t);
    chk("R2 old origin kept", a, 32'h1000);
    pulse_frame();
    send_pix(v, a, t);
    chk("R2 new origin at frame", a, 32'h8000);

    // R6: disable immediate, enable waits for frame
    wr(3'd0, 32'h1800_0000);
    chk("R6 off now", {31'd0, plane_on}, 32'd0);
    send_pix(v, a, t);
    chk("R6 no addr when off", {31'd0, v}, 32'd0);
    wr(3'd0, 32'h9800_0000);
    chk("R6 on waits", {31'd0, plane_on}, 32'd0);
    pulse_frame();
    chk("R6 on at frame", {31'd0, plane_on}, 32'd1);
    send_pix(v, a, t);
    chk("R6 addr after on", a, 32'h8000);

    // R5: bad format code 7
    wr(3'd0, 32'h9C00_0000);
    chk("R5 err set", {31'd0, fmt_err}, 32'd1);
    chk("R5 plane off", {31'd0, plane_on}, 32'd0);
    pulse_frame();
    chk("R5 stays off", {31'd0, plane_on}, 32'd0);
    send_pix(v, a, t);
    chk("R5 no addr", {31'd0, v}, 32'd0);
    wr(3'd0, 32'h9800_0000);
    chk("R5 sticky", {31'd0, fmt_err}, 32'd1);
    wr(3'd5, 32'h0);
    chk("R5 cleared", {31'd0, fmt_err}, 32'd0);

    // R10: back-pressure
    pulse_frame();
    @(negedge clk); out_ready = 1'b0;
    send_pix(v, a, t);
    chk("R10 held valid", {31'd0, v}, 32'd1);
    chk("R10 pix_ready low", {31'd0, pix_ready}, 32'd0);
    @(negedge clk); pix_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 addr stable", out_addr, 32'h8000);
    chk("R10 still valid", {31'd0, out_valid}, 32'd1);
    pix_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", {31'd0, out_valid}, 32'd0);
    send_pix(v, a, t);
    chk("R10 blocked pixel not counted", a, 32'h8004);

    // R10: sync strobe stalls pixel input
    @(negedge clk); frame_start = 1'b1;
    #1;
    chk("R10 stall on frame_start", {31'd0, pix_ready}, 32'd0);
    @(negedge clk); frame_start = 1'b0;

    // R11: line_start returns column to 0
    for (int p = 0; p < 3; p++) send_pix(v, a, t);
    chk("R11 column advance", a, 32'h8008);
    pulse_line();
    send_pix(v, a, t);
    chk("R11 next line col0", a, 32'h8100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule